// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block steps an external single-channel conversion engine through a chosen group of analog inputs, pass after pass, for as long as a run bit stays set. A software write, a timer trigger or an external trigger pin can set the run bit. When it goes from 0 to 1, the sequencer captures the group and channel-count selects. It then issues a one-cycle start pulse with a 3-bit channel number to the converter and waits for a one-cycle done strobe that carries the 10-bit result.

Each accepted result goes into one of four data slots, chosen by the low two bits of the channel number. After the last channel of the group, a sticky end-of-scan flag is set and the sequence wraps back to the first channel. Software clears the flag by writing one to it. The interrupt output is the flag gated by an interrupt-enable input. Clearing the run bit aborts the scan, and the result of any conversion still in flight is dropped.

Top module: `adcScanSeq`

## Requirements
- R1: Any one of swRun, timerTrig or extTrig, seen high while the block is stopped, sets running. In the next cycle convStart pulses with convChan equal to the first channel of the group: 0 for groupSel=0, 4 for groupSel=1.
- R2: convStart is high for exactly one cycle per conversion. A pass converts chanCnt+1 channels in ascending order, from groupSel*4 up to groupSel*4+chanCnt. The next start pulse comes in the cycle after a done strobe is accepted.
- R3: An accepted result is written to slot (channel mod 4) of resData, at bits [slot*10 +: 10]. Slots outside the group keep their values, and the reset value of every slot is 0.
- R4: When the done strobe of the last channel of the group is accepted, scanFlag is set and the next start is for the first channel of the group.
- R5: irq is high exactly when scanFlag and intEn are both high.
- R6: scanFlag stays set until a one-cycle flagClr pulse clears it. Stopping the scan does not clear it.
- R7: A runClr pulse clears running, and no further start pulses follow. A done strobe that arrives after the abort is ignored, so no slot changes. runClr beats a trigger in the same cycle.
- R8: After an abort, a new trigger restarts the scan from the first channel of the group, not from the channel where it stopped.
- R9: groupSel and chanCnt are captured in the cycle running goes from 0 to 1, including values that change in that same cycle. Changes made while running have no effect until the next start.
- R10: A trigger while running has no effect: the sequence carries on with the next channel and does not restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swRun | input | 1 | Software set of the run bit |
| timerTrig | input | 1 | Timer trigger that sets the run bit |
| extTrig | input | 1 | External trigger that sets the run bit |
| runClr | input | 1 | Clears the run bit and aborts the scan |
| groupSel | input | 1 | Group select: 0 for channels 0-3, 1 for channels 4-7 |
| chanCnt | input | 2 | Number of channels in the group, minus one |
| intEn | input | 1 | Interrupt enable |
| flagClr | input | 1 | Write-one-to-clear pulse for scanFlag |
| convStart | output | 1 | One-cycle start pulse to the converter |
| convChan | output | 3 | Channel number to convert |
| convDone | input | 1 | One-cycle conversion done strobe |
| convData | input | 10 | Conversion result |
| running | output | 1 | Run bit state |
| scanFlag | output | 1 | Sticky end-of-scan flag |
| irq | output | 1 | Interrupt request |
| resData | output | 40 | Four 10-bit result slots, slot 0 in the low bits |

## Verification
The assertions assume that the converter answers each start pulse with exactly one done strobe, a few cycles later and never in the same cycle as the start. They also assume that flagClr and the triggers are single-cycle pulses. The bench's converter model keeps a fixed three-cycle latency and keeps answering even after an abort, so stale strobes are part of the stimulus. After every abort the bench waits out the in-flight conversion before it triggers again, so a late strobe never falls inside a new run.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef struct packed {
    logic       wrEn;
    logic [1:0] wrSlot;
    logic       passDone;
  } scan_strobe_t;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int GROUP_CH   = 4,
  parameter int NUM_GROUPS = 2,
  localparam int IDX_W  = $clog2(GROUP_CH),
  localparam int GSEL_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int CH_W   = IDX_W + GSEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swRun,
  input  logic              timerTrig,
  input  logic              extTrig,
  input  logic              runClr,
  input  logic [GSEL_W-1:0] groupSel,
  input  logic [IDX_W-1:0]  chanCnt,
  input  logic              convDone,
  output logic              convStart,
  output logic [CH_W-1:0]   convChan,
  output logic              running,
  output scan_strobe_t      strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WAIT} state_t;

  state_t            state;
  logic              runQ;
  logic [IDX_W-1:0]  idxQ;
  logic [IDX_W-1:0]  cfgCnt;
  logic [GSEL_W-1:0] cfgGrp;
  logic              anyTrig;
  logic              startRun;
  logic              lastCh;

  assign anyTrig  = swRun | timerTrig | extTrig;
  assign startRun = anyTrig && !runClr && !runQ;
  assign lastCh   = (idxQ == cfgCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      state  <= ST_IDLE;
      idxQ   <= '0;
      cfgCnt <= '0;
      cfgGrp <= '0;
    end else if (runClr) begin
      runQ  <= 1'b0;
      state <= ST_IDLE;
    end else if (startRun) begin
      runQ   <= 1'b1;
      state  <= ST_START;
      idxQ   <= '0;
      cfgCnt <= chanCnt;
      cfgGrp <= groupSel;
    end else begin
      case (state)
        ST_START: state <= ST_WAIT;
        ST_WAIT: if (convDone) begin
          state <= ST_START;
          idxQ  <= lastCh ? '0 : idxQ + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.wrEn     = (state == ST_WAIT) && convDone && !runClr;
    strobe.wrSlot   = 2'(idxQ);
    strobe.passDone = strobe.wrEn && lastCh;
  end

  assign convStart = (state == ST_START);
  assign convChan  = {cfgGrp, idxQ};
  assign running   = runQ;

  // R1: a fresh run begins at the first channel of its group
  a_r1_first_chan: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> (convStart && convChan[IDX_W-1:0] == '0));
  // R2: start is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);
  // R2: an accepted result is followed at once by the next start
  a_r2_next_start: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> convStart);
  // R7: nothing is written while stopped
  a_r7_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |-> !strobe.wrEn);
  // R7: an abort halts all further starts
  a_r7_abort_stops: assert property (@(posedge clk) disable iff (!rstN)
    runClr |=> (!running && !convStart));
endmodule

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
#(
  parameter int GROUP_CH = 4,
  parameter int RES_W    = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  scan_strobe_t              strobe,
  input  logic [RES_W-1:0]          convData,
  input  logic                      flagClr,
  input  logic                      intEn,
  output logic                      scanFlag,
  output logic                      irq,
  output logic [GROUP_CH*RES_W-1:0] resData
);
  logic flagQ;

  for (genvar s = 0; s < GROUP_CH; s++) begin : g_slot
    logic [RES_W-1:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        slotQ <= '0;
      else if (strobe.wrEn && strobe.wrSlot == 2'(s))
        slotQ <= convData;
    end
    assign resData[s*RES_W +: RES_W] = slotQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      flagQ <= 1'b0;
    else if (strobe.passDone)
      flagQ <= 1'b1;
    else if (flagClr)
      flagQ <= 1'b0;
  end

  assign scanFlag = flagQ;
  assign irq      = flagQ & intEn;

  // R4: a completed pass raises the flag
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    strobe.passDone |=> scanFlag);
  // R6: the flag holds unless cleared
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (scanFlag && !flagClr) |=> scanFlag);
  // R3: slots change only on a write
  a_r3_slot_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(resData));
endmodule

// File: rtl/adcScanSeq.sv
module adcScanSeq
  import adc_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swRun,
  input  logic        timerTrig,
  input  logic        extTrig,
  input  logic        runClr,
  input  logic        groupSel,
  input  logic [1:0]  chanCnt,
  input  logic        intEn,
  input  logic        flagClr,
  output logic        convStart,
  output logic [2:0]  convChan,
  input  logic        convDone,
  input  logic [9:0]  convData,
  output logic        running,
  output logic        scanFlag,
  output logic        irq,
  output logic [39:0] resData
);
  scan_strobe_t strobe;

  adc_scan_ctrl #(.GROUP_CH(4), .NUM_GROUPS(2)) ctrl_i (
    .clk(clk), .rstN(rstN), .swRun(swRun), .timerTrig(timerTrig),
    .extTrig(extTrig), .runClr(runClr), .groupSel(groupSel),
    .chanCnt(chanCnt), .convDone(convDone), .convStart(convStart),
    .convChan(convChan), .running(running), .strobe(strobe)
  );

  adc_scan_dp #(.GROUP_CH(4), .RES_W(10)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .convData(convData),
    .flagClr(flagClr), .intEn(intEn), .scanFlag(scanFlag),
    .irq(irq), .resData(resData)
  );
endmodule

// File: tb/adcScanSeq_tb_top.sv
module adcScanSeq_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swRun = 0, timerTrig = 0, extTrig = 0, runClr = 0;
  logic groupSel = 0, intEn = 0, flagClr = 0;
  logic [1:0] chanCnt = 0;
  logic convStart, running, scanFlag, irq;
  logic [2:0] convChan;
  logic convDone = 0;
  logic [9:0] convData = 0;
  logic [39:0] resData;

  int errors = 0, checks = 0, cycles = 0;
  int logN = 0;
  logic [2:0] logCh [64];
  logic [9:0] lastData [8];
  int busyCnt = 0, seq = 1;
  logic [2:0] pendChan = 0;
  logic [9:0] pendData = 0;

  always #2 clk = ~clk;

  adcScanSeq dut_i (.*);

  // converter model: fixed latency, answers every start, even after an abort
  always @(posedge clk) begin
    convDone <= 1'b0;
    if (convDone) lastData[pendChan] <= convData;
    if (busyCnt > 0) begin
      busyCnt <= busyCnt - 1;
      if (busyCnt == 1) begin
        convDone <= 1'b1;
        convData <= pendData;
      end
    end
    if (convStart) begin
      busyCnt  <= 3;
      pendChan <= convChan;
      pendData <= 10'((seq * 37 + convChan * 5) % 1024);
      seq      <= seq + 1;
    end
  end

  always @(posedge clk) begin
    if (rstN && convStart) begin
      if (logN < 64) logCh[logN] = convChan;
      logN = logN + 1;
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [9:0] slot(int s);
    return resData[s*10 +: 10];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    cyc(1);
    sig = 1'b0;
  endtask

  task automatic waitFlag();
    int n = 0;
    while (!scanFlag && n < 300) begin
      cyc(1);
      n++;
    end
  endtask

  task automatic stopScan();
    pulse(runClr);
    cyc(10);
  endtask

  task automatic t_reset();
    chk(!running && !convStart, "R7 reset idle", running, 0);
    chk(!scanFlag && !irq, "R6 reset flag", scanFlag, 0);
    chk(resData == '0, "R3 reset slots", int'(resData[9:0]), 0);
  endtask

  task automatic t_scanThree();
    groupSel = 0; chanCnt = 2; intEn = 1;
    logN = 0;
    pulse(swRun);
    chk(convStart && convChan == 0, "R1 software start chan", convChan, 0);
    chk(running, "R1 running", running, 1);
    waitFlag();
    chk(scanFlag, "R4 flag after pass", scanFlag, 1);
    chk(irq, "R5 irq enabled", irq, 1);
    for (int s = 0; s < 3; s++)
      chk(slot(s) == lastData[s], "R3 slot value", slot(s), lastData[s]);
    chk(slot(3) == 0, "R3 unselected slot kept", slot(3), 0);
    cyc(3);
    chk(logN >= 4 && logCh[3] == 0, "R4 wrap to first", logCh[3], 0);
    for (int i = 0; i < 3; i++)
      chk(logCh[i] == 3'(i), "R2 ascending order", logCh[i], i);
  endtask

  task automatic t_irqMask();
    intEn = 0;
    cyc(1);
    chk(!irq && scanFlag, "R5 irq masked", irq, 0);
    intEn = 1;
    cyc(1);
    chk(irq, "R5 irq unmasked", irq, 1);
  endtask

  task automatic t_flag();
    stopScan();
    chk(scanFlag, "R6 flag survives stop", scanFlag, 1);
    pulse(flagClr);
    chk(!scanFlag && !irq, "R6 flag cleared", scanFlag, 0);
  endtask

  task automatic t_abort();
    logic [9:0] keep;
    int n = 0;
    groupSel = 0; chanCnt = 3;
    pulse(swRun);
    waitFlag();
    pulse(flagClr);
    while (!(convStart && convChan == 1) && n < 100) begin
      cyc(1);
      n++;
    end
    keep = slot(1);
    cyc(1);
    pulse(runClr);
    logN = 0;
    cyc(10);
    chk(slot(1) == keep, "R7 in-flight result dropped", slot(1), keep);
    chk(!running && logN == 0, "R7 no starts after abort", logN, 0);
    chk(!scanFlag, "R7 no flag after abort", scanFlag, 0);
  endtask

  task automatic t_restart();
    logN = 0;
    pulse(swRun);
    chk(convStart && convChan == 0, "R8 restart at first chan", convChan, 0);
    cyc(8);
    chk(logN >= 2 && logCh[1] == 1, "R8 continues in order", logCh[1], 1);
    stopScan();
  endtask

  task automatic t_sameCycleCfg();
    pulse(flagClr);
    groupSel = 1; chanCnt = 3;
    logN = 0;
    pulse(timerTrig);
    chk(convStart && convChan == 4, "R9 same-cycle group applies", convChan, 4);
    waitFlag();
    for (int s = 0; s < 4; s++)
      chk(slot(s) == lastData[4+s], "R3 group1 slot value", slot(s), lastData[4+s]);
    chk(logCh[3] == 7, "R2 group1 last chan", logCh[3], 7);
    stopScan();
    pulse(flagClr);
  endtask

  task automatic t_midChange();
    bit ok = 1;
    groupSel = 0; chanCnt = 1;
    logN = 0;
    pulse(extTrig);
    chk(convStart && convChan == 0, "R1 external trigger start", convChan, 0);
    groupSel = 1; chanCnt = 3;
    cyc(40);
    for (int i = 0; i < logN && i < 64; i++)
      if (logCh[i] != 3'(i % 2)) ok = 0;
    chk(ok && logN >= 4, "R9 change while running ignored", logN, 4);
    stopScan();
  endtask

  task automatic t_retrigger();
    int n = 0;
    groupSel = 0; chanCnt = 3;
    logN = 0;
    pulse(swRun);
    while (!(convStart && convChan == 2) && n < 100) begin
      cyc(1);
      n++;
    end
    pulse(swRun);
    pulse(timerTrig);
    n = logN;
    while (logN == n && n < 64) cyc(1);
    chk(logCh[n] == 3, "R10 retrigger keeps sequence", logCh[n], 3);
    stopScan();
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    t_reset();
    t_scanThree();
    t_irqMask();
    t_flag();
    t_abort();
    t_restart();
    t_sameCycleCfg();
    t_midChange();
    t_retrigger();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule